// File: doc/BRIEF.md
# Quad-SPI Indirect Command Sequencer

The sequencer sits on the controller side of a serial flash link and runs one command at a time over a four-line SPI bus. A command is made of up to five phases that always come in a fixed order: opcode, address, alternate byte, dummy clocks and data. Each phase is switched on or off by its own field, and the opcode, address, alternate and data phases each choose one, two or four lines. Software fills a handful of registers through a simple write port and drains received bytes through a pop port.

A transfer begins on a register write. When the address phase is off, writing the command-configuration register launches it. When the address phase is on, that write only stores the setup, and the transfer begins on the write of the address register. A configuration with no opcode, address, alternate or data phase never starts, so the bus stays quiet. In read mode, data bytes are assembled from the IO lines and placed in a small receive FIFO. The serial clock stops at a byte boundary whenever that FIFO is full, so a data-only read with no header phases still clocks every byte out of the device.

Top module: `qspi_cmd_seq`

## Requirements
- R1: After reset cs_n is 1, sclk is 0, io_oe and io_out are 0, and busy, rx_avail and xfer_done are 0.
- R2: Enabled phases are sent in the order opcode, address, alternate, dummy, data; a phase whose field is off is skipped with no clock cycles. An opcode-only command is legal.
- R3: Configuration register (reg_addr 0) fields: opcode [7:0], opcode lines [9:8], address lines [11:10], address bytes minus one [13:12], alternate lines [15:14], dummy count [20:16], data lines [22:21], direction [24:23]. A lines field of 00 turns the phase off; 01, 10 and 11 use one, two and four lines. Bits go MSB first. One line drives io_out[0] (io_oe 0001) and samples io_in[1]; two lines use bits [1:0] (io_oe 0011); four lines use [3:0] (io_oe 1111). The address register is reg_addr 1, and the low address bytes are sent, the most significant first.
- R4: With address lines 00, a configuration write starts the transfer. With address lines not 00, a configuration write does not start it, and a later address-register write does.
- R5: No transfer starts when opcode, address and alternate are off and the data phase is off (data lines 00 or length 0), even with dummy clocks set. It also does not start when the direction field is 10 or 11.
- R6: A data-only read gives exactly length×8/lines sclk pulses, and cs_n stays low across them.
- R7: cs_n falls at the clock edge that registers the start write, and sclk first rises on the next clock edge. cs_n rises together with the last falling sclk edge.
- R8: With direction 01 (read), io_oe is 0 throughout the data phase. Lines are sampled when sclk rises, each byte is assembled MSB first, reg_rdata shows the oldest byte, and reg_rd pops it.
- R9: In a read, the sclk is held low at a byte boundary while the receive FIFO (default depth 4) is full, and it resumes after a pop with no byte lost or repeated.
- R10: rx_avail is 1 exactly when the receive FIFO holds a byte. xfer_done is set when the last phase ends (data: byte count equals the length register, reg_addr 2) and is cleared by the next start.
- R11: With direction 00 (write), data byte n is byte (n mod 4) of the data register (reg_addr 3), taking byte 0 from bits [7:0]. The alternate byte is reg_addr 4 [7:0].
- R12: Register writes made while busy is 1 are ignored and do not change the running transfer.
- R13: The dummy phase gives exactly the programmed number of sclk pulses with io_oe 0, and a count of 0 skips it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select for writes |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Pop one byte from the receive FIFO |
| reg_rdata | output | 8 | Oldest byte in the receive FIFO |
| busy | output | 1 | Transfer in progress |
| rx_avail | output | 1 | Receive FIFO holds at least one byte |
| xfer_done | output | 1 | Last transfer has finished |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Chip select, active low |
| io_out | output | 4 | Values driven on the IO lines |
| io_oe | output | 4 | Per-line output enable |
| io_in | input | 4 | Values sampled from the IO lines |

## Verification
The bench targets the data-only read with no header phases. A sequencer that needs a header phase to get going would produce no clock pulses there, or too few. It also targets the trigger split between the configuration write and the address write: a wrong decode would start early, before the address is loaded, or never start at all. A read longer than the receive FIFO checks that the clock halts at exactly 34 pulses and later resumes; a design without the stall would overrun the FIFO or drop bytes. Writes issued during a transfer check that the length and configuration cannot be altered while the transfer runs, since that would change its pulse count or byte count.

// File: rtl/qspi_seq_pkg.sv
package qspi_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_INS  = 3'd1,
        PH_ADR  = 3'd2,
        PH_ALT  = 3'd3,
        PH_DUM  = 3'd4,
        PH_DAT  = 3'd5
    } phase_e;

    typedef struct packed {
        logic [1:0] fmode;
        logic [1:0] dat_mode;
        logic [4:0] dummy;
        logic [1:0] alt_mode;
        logic [1:0] adr_size;
        logic [1:0] adr_mode;
        logic [1:0] ins_mode;
        logic [7:0] opcode;
    } cfg_t;

    localparam logic [1:0] FM_WRITE = 2'b00;
    localparam logic [1:0] FM_READ  = 2'b01;

    localparam logic [2:0] RA_CFG  = 3'd0;
    localparam logic [2:0] RA_ADDR = 3'd1;
    localparam logic [2:0] RA_LEN  = 3'd2;
    localparam logic [2:0] RA_DATA = 3'd3;
    localparam logic [2:0] RA_ALT  = 3'd4;

    // log2 of the line count for an enabled lines field
    function automatic logic [1:0] lane_shift(logic [1:0] mode);
        return mode - 2'd1;
    endfunction

endpackage

// File: rtl/qspi_rx_fifo.sv
module qspi_rx_fifo #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [AW-1:0]               wp;
        logic [AW-1:0]               rp;
        logic [AW:0]                 cnt;
    } fifo_t;

    fifo_t q, d;
    logic  do_push, do_pop;

    always_comb begin
        d       = q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) begin
            d.mem[q.wp] = din;
            d.wp = (q.wp == AW'(DEPTH - 1)) ? '0 : q.wp + AW'(1);
        end
        if (do_pop) begin
            d.rp = (q.rp == AW'(DEPTH - 1)) ? '0 : q.rp + AW'(1);
        end
        d.cnt = q.cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign head  = q.mem[q.rp];
    assign empty = (q.cnt == '0);
    assign full  = (q.cnt == (AW+1)'(DEPTH));

    // R9: the stall logic upstream must never push into a full FIFO
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R10: level never exceeds the depth
    a_r10_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= (AW+1)'(DEPTH));

endmodule

// File: rtl/qspi_lane_io.sv
module qspi_lane_io (
    input  logic [1:0] mode,
    input  logic       drive,
    input  logic [3:0] tx_top,
    input  logic [3:0] io_in,
    input  logic [7:0] rx_in,
    output logic [3:0] io_out,
    output logic [3:0] io_oe,
    output logic [7:0] rx_out
);
    always_comb begin
        io_out = 4'b0000;
        io_oe  = 4'b0000;
        rx_out = rx_in;
        case (mode)
            2'b01: begin
                if (drive) begin
                    io_out = {3'b000, tx_top[3]};
                    io_oe  = 4'b0001;
                end
                rx_out = {rx_in[6:0], io_in[1]};
            end
            2'b10: begin
                if (drive) begin
                    io_out = {2'b00, tx_top[3:2]};
                    io_oe  = 4'b0011;
                end
                rx_out = {rx_in[5:0], io_in[1:0]};
            end
            2'b11: begin
                if (drive) begin
                    io_out = tx_top;
                    io_oe  = 4'b1111;
                end
                rx_out = {rx_in[3:0], io_in};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/qspi_cmd_seq.sv
module qspi_cmd_seq
    import qspi_seq_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int LEN_W      = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    input  logic        reg_rd,
    output logic [7:0]  reg_rdata,
    output logic        busy,
    output logic        rx_avail,
    output logic        xfer_done,
    output logic        sclk,
    output logic        cs_n,
    output logic [3:0]  io_out,
    output logic [3:0]  io_oe,
    input  logic [3:0]  io_in
);
    localparam int ADR_W = 32;
    localparam int CNT_W = $clog2(ADR_W + 1);
    localparam int CFG_W = $bits(cfg_t);

    typedef struct packed {
        phase_e           ph;
        logic             half;
        logic [CNT_W-1:0] cnt;
        logic [ADR_W-1:0] sreg;
        logic [7:0]       rx;
        logic [LEN_W-1:0] nbytes;
        cfg_t             cfg;
        logic [ADR_W-1:0] addr;
        logic [7:0]       alt;
        logic [LEN_W-1:0] len;
        logic [31:0]      tx;
        logic             done;
    } st_t;

    function automatic logic [CNT_W-1:0] unit_cycles(cfg_t c, phase_e p);
        case (p)
            PH_INS:  return CNT_W'(8) >> lane_shift(c.ins_mode);
            PH_ADR:  return ((CNT_W'(c.adr_size) + CNT_W'(1)) << 3) >> lane_shift(c.adr_mode);
            PH_ALT:  return CNT_W'(8) >> lane_shift(c.alt_mode);
            PH_DUM:  return CNT_W'(c.dummy);
            PH_DAT:  return CNT_W'(8) >> lane_shift(c.dat_mode);
            default: return '0;
        endcase
    endfunction

    function automatic logic [ADR_W-1:0] unit_word(cfg_t c, phase_e p, logic [ADR_W-1:0] a,
                                                   logic [7:0] al, logic [31:0] t, logic [1:0] bi);
        logic [31:0] sel;
        sel = t >> {bi, 3'b000};
        case (p)
            PH_INS:  return {c.opcode, 24'h0};
            PH_ADR:  return a << {2'd3 - c.adr_size, 3'b000};
            PH_ALT:  return {al, 24'h0};
            PH_DAT:  return {sel[7:0], 24'h0};
            default: return '0;
        endcase
    endfunction

    function automatic phase_e first_phase(cfg_t c, logic len_nz, logic [2:0] from);
        logic [4:0] en;
        en = {c.dat_mode != 2'b00 && len_nz, c.dummy != 5'd0, c.alt_mode != 2'b00,
              c.adr_mode != 2'b00, c.ins_mode != 2'b00};
        for (int k = 0; k < 5; k++) begin
            if (3'(k) >= from && en[k]) return phase_e'(3'(k + 1));
        end
        return PH_IDLE;
    endfunction

    function automatic logic [1:0] phase_mode(cfg_t c, phase_e p);
        case (p)
            PH_INS:  return c.ins_mode;
            PH_ADR:  return c.adr_mode;
            PH_ALT:  return c.alt_mode;
            PH_DAT:  return c.dat_mode;
            default: return 2'b00;
        endcase
    endfunction

    st_t        q, d;
    cfg_t       wcfg;
    logic       push, pop, start, legal, stall, is_read, drive;
    logic [1:0] cur_mode;
    logic [2:0] shamt;
    phase_e     first, nxt;
    logic [7:0] rx_next;
    logic       rx_empty, rx_full;

    assign wcfg = cfg_t'(reg_wdata[CFG_W-1:0]);

    always_comb begin
        d        = q;
        push     = 1'b0;
        pop      = reg_rd && !rx_empty;
        start    = 1'b0;
        legal    = 1'b0;
        stall    = 1'b0;
        first    = PH_IDLE;
        nxt      = PH_IDLE;
        is_read  = (q.cfg.fmode == FM_READ);
        cur_mode = phase_mode(q.cfg, q.ph);
        shamt    = (cur_mode == 2'b11) ? 3'd4 : (cur_mode == 2'b10) ? 3'd2 : 3'd1;
        drive    = (q.ph == PH_INS) || (q.ph == PH_ADR) || (q.ph == PH_ALT) ||
                   (q.ph == PH_DAT && !is_read);

        if (q.ph == PH_IDLE) begin
            if (reg_wr) begin
                case (reg_addr)
                    RA_CFG: begin
                        d.cfg = wcfg;
                        start = (wcfg.adr_mode == 2'b00);
                    end
                    RA_ADDR: begin
                        d.addr = reg_wdata;
                        start  = (q.cfg.adr_mode != 2'b00);
                    end
                    RA_LEN:  d.len = reg_wdata[LEN_W-1:0];
                    RA_DATA: d.tx  = reg_wdata;
                    RA_ALT:  d.alt = reg_wdata[7:0];
                    default: ;
                endcase
            end
            first = first_phase(d.cfg, d.len != '0, 3'd0);
            legal = (d.cfg.fmode == FM_READ || d.cfg.fmode == FM_WRITE) &&
                    (d.cfg.ins_mode != 2'b00 || d.cfg.adr_mode != 2'b00 ||
                     d.cfg.alt_mode != 2'b00 || (d.cfg.dat_mode != 2'b00 && d.len != '0));
            if (start && legal) begin
                d.ph     = first;
                d.half   = 1'b0;
                d.cnt    = unit_cycles(d.cfg, first);
                d.sreg   = unit_word(d.cfg, first, d.addr, d.alt, d.tx, 2'd0);
                d.nbytes = '0;
                d.rx     = '0;
                d.done   = 1'b0;
            end
        end else if (!q.half) begin
            stall = (q.ph == PH_DAT) && is_read && rx_full &&
                    (q.cnt == unit_cycles(q.cfg, PH_DAT));
            if (!stall) begin
                d.half = 1'b1;
                if (q.ph == PH_DAT && is_read) d.rx = rx_next;
            end
        end else begin
            d.half = 1'b0;
            d.sreg = q.sreg << shamt;
            d.cnt  = q.cnt - CNT_W'(1);
            if (q.cnt == CNT_W'(1)) begin
                if (q.ph == PH_DAT) begin
                    d.nbytes = q.nbytes + LEN_W'(1);
                    push     = is_read;
                    if (d.nbytes == q.len) begin
                        d.ph   = PH_IDLE;
                        d.done = 1'b1;
                    end else begin
                        d.cnt  = unit_cycles(q.cfg, PH_DAT);
                        d.sreg = unit_word(q.cfg, PH_DAT, q.addr, q.alt, q.tx, d.nbytes[1:0]);
                    end
                end else begin
                    nxt  = first_phase(q.cfg, q.len != '0, q.ph);
                    d.ph = nxt;
                    if (nxt == PH_IDLE) begin
                        d.done = 1'b1;
                    end else begin
                        d.cnt  = unit_cycles(q.cfg, nxt);
                        d.sreg = unit_word(q.cfg, nxt, q.addr, q.alt, q.tx, 2'd0);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    qspi_lane_io u_lanes (
        .mode   (cur_mode),
        .drive  (drive),
        .tx_top (q.sreg[ADR_W-1 -: 4]),
        .io_in  (io_in),
        .rx_in  (q.rx),
        .io_out (io_out),
        .io_oe  (io_oe),
        .rx_out (rx_next)
    );

    qspi_rx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   (q.rx),
        .pop   (pop),
        .head  (reg_rdata),
        .empty (rx_empty),
        .full  (rx_full)
    );

    assign busy      = (q.ph != PH_IDLE);
    assign cs_n      = (q.ph == PH_IDLE);
    assign sclk      = q.half;
    assign rx_avail  = !rx_empty;
    assign xfer_done = q.done;

    // R7: no clock pulse outside chip select
    a_r7_sclk_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);

    // R6: each high half lasts one cycle
    a_r6_sclk_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |=> !sclk);

    // R5: a configuration without any payload phase never opens the bus
    a_r5_no_empty_start: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RA_CFG && cs_n && wcfg.ins_mode == 2'b00 &&
         wcfg.adr_mode == 2'b00 && wcfg.alt_mode == 2'b00 && wcfg.dat_mode == 2'b00) |=> cs_n);

    // R8: lines released while the device drives read data
    a_r8_read_released: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_DAT && is_read) |-> (io_oe == 4'b0000));

    // R12: configuration frozen while a transfer runs
    a_r12_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(q.cfg));

endmodule

// File: tb/tb_qspi_cmd_seq.sv
`timescale 1ns/1ps
module tb_qspi_cmd_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_rdata;
    logic        busy, rx_avail, xfer_done, sclk, cs_n;
    logic [3:0]  io_out, io_oe, io_in;

    int nchk = 0, nfail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    qspi_cmd_seq dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .busy(busy), .rx_avail(rx_avail), .xfer_done(xfer_done),
        .sclk(sclk), .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
    );

    // Bus log: one entry per rising sclk edge
    logic [7:0] log_q [0:1023];
    int ecnt = 0;
    always @(posedge sclk) begin
        log_q[ecnt % 1024] = {io_oe, io_out};
        ecnt++;
    end

    // Device model: returns pat() bytes MSB first once dev_base edges have passed
    int dev_base = 1 << 20;
    int dev_w = 1;

    function automatic logic [7:0] pat(int i);
        return 8'(8'h3C + i * 37);
    endfunction

    function automatic logic [3:0] dev_chunk(int k, int w);
        logic [7:0] b;
        int j;
        if (k < 0) return 4'b0000;
        j = k * w;
        b = pat(j / 8) << (j % 8);
        case (w)
            1:       return {2'b00, b[7], 1'b0};
            2:       return {2'b00, b[7:6]};
            default: return b[7:4];
        endcase
    endfunction

    always_comb io_in = dev_chunk(ecnt - dev_base, dev_w);

    // Expected bus log
    logic [7:0] exp_q [0:255];
    int nexp = 0;

    task automatic exp_tx(input logic [31:0] v, input int nbits, input int w);
        for (int i = 0; i < nbits / w; i++) begin
            logic [31:0] s;
            s = v << (i * w);
            case (w)
                1:       exp_q[nexp] = {4'b0001, 3'b000, s[31]};
                2:       exp_q[nexp] = {4'b0011, 2'b00, s[31:30]};
                default: exp_q[nexp] = {4'b1111, s[31:28]};
            endcase
            nexp++;
        end
    endtask

    task automatic exp_quiet(input int n);
        for (int i = 0; i < n; i++) begin
            exp_q[nexp] = 8'h00;
            nexp++;
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cmp_log(input string tag, input int base);
        int bad;
        bad = 0;
        chk({tag, " edge count"}, ecnt - base, nexp);
        for (int i = 0; i < nexp; i++) begin
            if (log_q[(base + i) % 1024] !== exp_q[i] && bad == 0) begin
                bad = 1;
                chk({tag, " bus log"}, {i[23:0], log_q[(base + i) % 1024]}, {i[23:0], exp_q[i]});
            end
        end
        if (bad == 0) chk({tag, " bus log"}, 0, 0);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pop_chk(input string tag, input logic [7:0] e);
        chk(tag, reg_rdata, e);
        reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        int n;
        n = 0;
        while (busy && n < 4000) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " finished"}, busy, 0);
    endtask

    function automatic logic [31:0] mk_cfg(logic [1:0] fm, logic [1:0] dat, logic [4:0] dum,
                                           logic [1:0] alt, logic [1:0] asz, logic [1:0] adr,
                                           logic [1:0] ins, logic [7:0] op);
        return {7'b0, fm, dat, dum, alt, asz, adr, ins, op};
    endfunction

    task automatic t_reset();
        chk("R1 cs_n", cs_n, 1);
        chk("R1 sclk", sclk, 0);
        chk("R1 io_oe/io_out", {io_oe, io_out}, 0);
        chk("R1 busy/rx_avail/xfer_done", {busy, rx_avail, xfer_done}, 0);
    endtask

    task automatic t_quad_data_only();
        int base;
        base = ecnt; dev_base = base; dev_w = 4; nexp = 0;
        wr(3'd2, 32'd4);
        wr(3'd0, mk_cfg(2'b01, 2'b11, 5'd0, 2'b00, 2'b00, 2'b00, 2'b00, 8'hEB));
        chk("R7 cs_n low after start write", cs_n, 0);
        chk("R7 sclk still low", sclk, 0);
        chk("R4 cfg write starts without address", busy, 1);
        @(negedge clk);
        chk("R7 first sclk rise next cycle", sclk, 1);
        wait_idle("R6 quad read");
        chk("R7 cs_n high at end", cs_n, 1);
        exp_quiet(8);
        cmp_log("R6 R13 data-only quad read", base);
        chk("R10 rx_avail set", rx_avail, 1);
        chk("R10 xfer_done set", xfer_done, 1);
        for (int i = 0; i < 4; i++) pop_chk("R8 quad byte", pat(i));
        chk("R10 rx_avail clear after drain", rx_avail, 0);
    endtask

    task automatic t_write_full();
        int base;
        nexp = 0;
        wr(3'd2, 32'd2);
        wr(3'd3, 32'hC3A5_5A17);
        wr(3'd4, 32'h0000_0096);
        wr(3'd0, mk_cfg(2'b00, 2'b01, 5'd2, 2'b10, 2'b10, 2'b11, 2'b01, 8'h9C));
        repeat (3) @(negedge clk);
        chk("R4 cfg write with address does not start", {busy, cs_n}, 2'b01);
        base = ecnt;
        wr(3'd1, 32'h00AB_CDEF);
        chk("R4 address write starts", busy, 1);
        chk("R10 xfer_done cleared by start", xfer_done, 0);
        wait_idle("R2 full write");
        exp_tx({8'h9C, 24'h0}, 8, 1);
        exp_tx(32'hABCD_EF00, 24, 4);
        exp_tx({8'h96, 24'h0}, 8, 2);
        exp_quiet(2);
        exp_tx({8'h17, 24'h0}, 8, 1);
        exp_tx({8'h5A, 24'h0}, 8, 1);
        cmp_log("R2 R3 R11 R13 five-phase write", base);
        chk("R10 write sets done, no rx data", {xfer_done, rx_avail}, 2'b10);
    endtask

    task automatic t_quad_opcode_only();
        int base;
        base = ecnt; nexp = 0;
        wr(3'd0, mk_cfg(2'b00, 2'b00, 5'd0, 2'b00, 2'b00, 2'b00, 2'b11, 8'hA7));
        wait_idle("R2 opcode only");
        exp_tx({8'hA7, 24'h0}, 8, 4);
        cmp_log("R2 R3 opcode-only on four lines", base);
    endtask

    task automatic t_invalid();
        int base;
        base = ecnt;
        wr(3'd2, 32'd0);
        wr(3'd0, mk_cfg(2'b01, 2'b00, 5'd0, 2'b00, 2'b00, 2'b00, 2'b00, 8'h03));
        repeat (4) @(negedge clk);
        chk("R5 all phases off", {busy, cs_n}, 2'b01);
        wr(3'd0, mk_cfg(2'b01, 2'b11, 5'd0, 2'b00, 2'b00, 2'b00, 2'b00, 8'h03));
        repeat (4) @(negedge clk);
        chk("R5 data on with length 0", {busy, cs_n}, 2'b01);
        wr(3'd0, mk_cfg(2'b01, 2'b00, 5'd4, 2'b00, 2'b00, 2'b00, 2'b00, 8'h03));
        repeat (4) @(negedge clk);
        chk("R5 dummy only", {busy, cs_n}, 2'b01);
        wr(3'd0, mk_cfg(2'b10, 2'b00, 5'd0, 2'b00, 2'b00, 2'b00, 2'b01, 8'h03));
        repeat (4) @(negedge clk);
        chk("R5 direction 10", {busy, cs_n}, 2'b01);
        chk("R5 no sclk pulses", ecnt - base, 0);
    endtask

    task automatic t_stall();
        int base;
        base = ecnt; dev_base = base + 2; dev_w = 1; nexp = 0;
        wr(3'd2, 32'd6);
        wr(3'd0, mk_cfg(2'b01, 2'b01, 5'd2, 2'b00, 2'b00, 2'b00, 2'b00, 8'h00));
        repeat (120) @(negedge clk);
        chk("R9 still busy while FIFO full", busy, 1);
        chk("R9 clock held after four bytes", ecnt - base, 34);
        chk("R9 sclk parked low", sclk, 0);
        for (int i = 0; i < 4; i++) pop_chk("R9 byte before stall", pat(i));
        wait_idle("R9 resumed read");
        exp_quiet(50);
        cmp_log("R9 R13 dummy then single-line read", base);
        pop_chk("R9 byte after resume", pat(4));
        pop_chk("R9 byte after resume", pat(5));
        chk("R9 nothing extra", rx_avail, 0);
    endtask

    task automatic t_busy_ignored();
        int base;
        base = ecnt; dev_base = base + 8; dev_w = 2; nexp = 0;
        wr(3'd2, 32'd2);
        wr(3'd0, mk_cfg(2'b01, 2'b10, 5'd0, 2'b00, 2'b00, 2'b00, 2'b01, 8'h3B));
        wr(3'd2, 32'd5);
        wr(3'd0, mk_cfg(2'b01, 2'b00, 5'd0, 2'b00, 2'b00, 2'b00, 2'b01, 8'h3B));
        wait_idle("R12 busy writes");
        exp_tx({8'h3B, 24'h0}, 8, 1);
        exp_quiet(8);
        cmp_log("R12 R3 writes while busy ignored", base);
        pop_chk("R12 dual byte", pat(0));
        pop_chk("R12 dual byte", pat(1));
        chk("R12 length unchanged", rx_avail, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_quad_data_only();
        t_write_full();
        t_quad_opcode_only();
        t_invalid();
        t_stall();
        t_busy_ignored();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule